// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. A pulse on the start input captures both operands. The block then retires two multiplier bits on each clock. For each pair it looks at a three-bit window: the pair itself plus the bit just below it, with an implied zero below the least significant bit. That window becomes a signed digit between -2 and +2. The block adds the matching multiple of the multiplicand into an accumulator that is two bits wider than the operands, then shifts the accumulator and the consumed multiplier bits right by two places, carrying the sign down.

Two pieces of logic build each multiple. A one-place left shift gives twice the multiplicand. Negation is a bitwise inversion with a carry of one injected into the adder. Every multiple is sign-extended to the accumulator width. After `WIDTH/2` steps the done flag rises. The result and the flag then hold until the next accepted start. A start that arrives while a product is still in progress is dropped.

Top module: `booth_mul`

## Requirements
- R1: While reset is held and after its release, before any start, `done_o` is 0 and `product_o` is 0.
- R2: Each digit comes from the window (bit i+1, bit i, bit i-1) of the multiplier. The window maps to a digit as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. The bench verifies this through the products of all 4-bit operand pairs.
- R3: The bit below the multiplier's least significant bit is taken as 0. A multiplier of 1 therefore yields exactly the multiplicand.
- R4: `product_o` equals the signed product of the captured operands as a 2*WIDTH-bit two's-complement value. This includes the most negative value times itself, and the most negative value times the most positive value.
- R5: `done_o` rises exactly WIDTH/2 clock cycles after the clock edge that accepts a start.
- R6: Once `done_o` is 1, it stays 1 and `product_o` stays unchanged until a new start is accepted.
- R7: A start asserted while a multiplication is in progress is ignored. The running result and its completion cycle do not change.
- R8: A start accepted while `done_o` is 1 clears `done_o` on the next cycle.
- R9: Multiples of a negative multiplicand are sign-extended, so negative-by-positive products come out correct.
- R10: With WIDTH=4, a multiplicand of 0110 and a multiplier of 1010 give 11011100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and begin; ignored while busy |
| multiplicand_i | input | WIDTH | Signed multiplicand |
| multiplier_i | input | WIDTH | Signed multiplier |
| product_o | output | 2*WIDTH | Signed product, valid while done_o is 1 |
| done_o | output | 1 | Product ready, held until next accepted start |

## Verification
The hardest cases to reach are the accumulator extremes. They occur when the -2 and +2 digits meet the most negative multiplicand, and random operands seldom produce them. The bench therefore drives directed extreme pairs and runs every pair of a 4-bit instance, which covers every window code under every multiplicand. The in-flight start is produced by raising start one cycle after an accepted start, with different operands. The per-clock model must then show that neither the result nor the completion cycle moves.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic [2:0]   win_i,
  output booth_digit_t digit_o
);
  always_comb begin
    digit_o = '0;
    unique case (win_i)
      3'b001, 3'b010: digit_o.one = 1'b1;
      3'b011:         digit_o.two = 1'b1;
      3'b100:         begin digit_o.two = 1'b1; digit_o.neg = 1'b1; end
      3'b101, 3'b110: begin digit_o.one = 1'b1; digit_o.neg = 1'b1; end
      default:        digit_o = '0;
    endcase
  end
endmodule

// File: rtl/booth_multiple_gen.sv
module booth_multiple_gen
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int ACC_W = WIDTH + 2
) (
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_digit_t     digit_i,
  output logic [ACC_W-1:0] mult_o,
  output logic             cin_o
);
  logic [ACC_W-1:0] mag;

  always_comb begin
    if (digit_i.two)      mag = {mcand_i[WIDTH-1], mcand_i, 1'b0};
    else if (digit_i.one) mag = {{2{mcand_i[WIDTH-1]}}, mcand_i};
    else                  mag = '0;
    // negation: invert here, +1 enters as adder carry
    mult_o = digit_i.neg ? ~mag : mag;
    cin_o  = digit_i.neg;
  end
endmodule

// File: rtl/booth_shift_add.sv
module booth_shift_add #(
  parameter int WIDTH = 16,
  localparam int ACC_W = WIDTH + 2
) (
  input  logic [ACC_W-1:0] hi_i,
  input  logic [WIDTH-1:0] lo_i,
  input  logic [ACC_W-1:0] mult_i,
  input  logic             cin_i,
  output logic [ACC_W-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             xm1_o
);
  logic [ACC_W-1:0] sum;

  always_comb begin
    sum   = hi_i + mult_i + {{(ACC_W-1){1'b0}}, cin_i};
    hi_o  = {{2{sum[ACC_W-1]}}, sum[ACC_W-1:2]};
    lo_o  = {sum[1:0], lo_i[WIDTH-1:2]};
    xm1_o = lo_i[1];
  end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               done_o
);
  localparam int ACC_W = WIDTH + 2;
  localparam int STEPS = WIDTH / 2;
  localparam int CNT_W = $clog2(STEPS + 1);

  if (WIDTH % 2 != 0 || WIDTH < 4) begin : g_bad_width
    initial $error("booth_mul: WIDTH must be even and at least 4");
  end

  logic             busy_q, done_q, xm1_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] a_q, lo_q, lo_n;
  logic [ACC_W-1:0] hi_q, hi_n, mult;
  logic             cin, xm1_n, accept;
  booth_digit_t     digit;

  assign accept = start_i && !busy_q;

  booth_recoder u_rec (
    .win_i   ({lo_q[1:0], xm1_q}),
    .digit_o (digit)
  );

  booth_multiple_gen #(.WIDTH(WIDTH)) u_mgen (
    .mcand_i (a_q),
    .digit_i (digit),
    .mult_o  (mult),
    .cin_o   (cin)
  );

  booth_shift_add #(.WIDTH(WIDTH)) u_step (
    .hi_i   (hi_q),
    .lo_i   (lo_q),
    .mult_i (mult),
    .cin_i  (cin),
    .hi_o   (hi_n),
    .lo_o   (lo_n),
    .xm1_o  (xm1_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      xm1_q  <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= multiplicand_i;
      hi_q   <= '0;
      lo_q   <= multiplier_i;
      xm1_q  <= 1'b0;
    end else if (busy_q) begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      xm1_q <= xm1_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(STEPS - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign product_o = {hi_q[WIDTH-1:0], lo_q};
  assign done_o    = done_q;

  // independent cycle counter for the latency check
  logic [CNT_W:0] chk_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          chk_cnt_q <= '0;
    else if (accept)      chk_cnt_q <= '0;
    else if (busy_q)      chk_cnt_q <= chk_cnt_q + 1'b1;
  end

  // R5
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> chk_cnt_q == (CNT_W+1)'(STEPS));

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(product_o));

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(a_q));

  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && done_o |=> !done_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_q) && !busy_q && !done_o && !$past(start_i) |-> product_o == $past(product_o));
endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int W  = 16;
  localparam int ST = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, x = '0;
  logic [2*W-1:0] prod;
  logic done;

  logic start4 = 1'b0;
  logic [3:0] a4 = '0, x4 = '0;
  logic [7:0] prod4;
  logic done4;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  booth_mul #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .multiplicand_i(a), .multiplier_i(x),
    .product_o(prod), .done_o(done)
  );

  booth_mul #(.WIDTH(4)) u_dut_w4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start4),
    .multiplicand_i(a4), .multiplier_i(x4),
    .product_o(prod4), .done_o(done4)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference, stepped every clock
  bit             m_busy, m_done;
  int             m_cnt;
  logic [2*W-1:0] m_prod;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_prod <= '0;
    end else if (start && !m_busy) begin
      m_busy <= 1'b1; m_done <= 1'b0; m_cnt <= 0;
      m_prod <= (2*W)'(longint'($signed(a)) * longint'($signed(x)));
    end else if (m_busy) begin
      m_cnt <= m_cnt + 1;
      if (m_cnt == ST - 1) begin
        m_busy <= 1'b0; m_done <= 1'b1;
      end
    end
  end

  // per-clock compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == m_done, "R5 done timing", longint'(done), longint'(m_done));
      if (m_done)
        chk(prod == m_prod, "R4/R6 product", longint'(prod), longint'(m_prod));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic run_op(input logic [W-1:0] av, input logic [W-1:0] xv, input string req);
    longint exp;
    exp = longint'($signed(av)) * longint'($signed(xv));
    @(negedge clk);
    a = av; x = xv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (ST) @(negedge clk);
    chk(done === 1'b1 && prod == (2*W)'(exp), req, longint'(prod), exp);
  endtask

  initial begin
    // R1
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && prod == '0, "R1 in reset", longint'(prod), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && prod == '0, "R1 after reset", longint'(prod), 0);

    run_op(16'd1234, 16'd1, "R3 multiplier one");
    run_op(16'd0, 16'd0, "R4 zero");
    run_op(16'hFFFF, 16'hFFFF, "R4 minus one squared");
    run_op(16'h8000, 16'h8000, "R4 min squared");
    run_op(16'h8000, 16'h7FFF, "R4 min times max");
    run_op(16'h7FFF, 16'h7FFF, "R4 max squared");
    run_op(16'h8000, 16'hFFFF, "R4 min times minus one");
    run_op(16'hFFFD, 16'd3, "R9 negative multiplicand");
    run_op(16'h8001, 16'h5555, "R9 negative multiplicand alternating");
    run_op(16'h1357, 16'hAAAA, "R2 alternating multiplier");
    run_op(16'h7ABC, 16'h3333, "R2 paired ones");
    for (int i = 0; i < 40; i++)
      run_op(W'($urandom), W'($urandom), "R4 random");

    // R6: hold over idle cycles, compared each clock by the model
    repeat (6) @(negedge clk);
    chk(done == 1'b1, "R6 hold", longint'(done), 1);

    // R8 + R7: restart from done, then an in-flight start
    @(negedge clk);
    a = 16'h00F3; x = 16'hFF11; start = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R8 done cleared", longint'(done), 0);
    a = 16'h7777; x = 16'h8888;              // still start=1: must be ignored
    @(negedge clk);
    start = 1'b0;
    repeat (ST - 1) @(negedge clk);
    chk(done == 1'b1 && prod == (2*W)'(longint'(16'sh00F3) * longint'(-16'sh00EF)),
        "R7 in-flight start ignored", longint'(prod),
        longint'(16'sh00F3) * longint'(-16'sh00EF));

    // R10 and R2: every 4-bit pair
    for (int ia = 0; ia < 16; ia++) begin
      for (int ix = 0; ix < 16; ix++) begin
        longint e4;
        e4 = longint'($signed(4'(ia))) * longint'($signed(4'(ix)));
        @(negedge clk);
        a4 = 4'(ia); x4 = 4'(ix); start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        repeat (2) @(negedge clk);
        if (ia == 6 && ix == 10)
          chk(done4 && prod4 == 8'b1101_1100, "R10 worked example", longint'(prod4), 8'hDC);
        else
          chk(done4 && prod4 == 8'(e4), "R2 window recoding", longint'(prod4), e4);
      end
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule